// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns a wide parallel pixel word into narrow serial lanes for a display cable. On each falling edge of the pixel clock it captures a 28-bit word: 24 colour bits (8 each for red, green and blue) and 4 timing bits (line sync, frame sync, data enable and a spare control bit). It then sends the word over four data lanes, seven bits per lane per pixel period. A fifth lane repeats a fixed seven-bit pattern in every slot, so the far end can recover both the clock and the slot boundary.

The serial side runs on a bit clock at seven times the pixel clock. Both clocks come from the same external PLL with a fixed phase relation. A one-cycle slot strobe in the bit-clock domain marks the last bit cycle of each slot. The lane outputs feed pad tri-state buffers through a shared output enable. An active-low power-down input drops that enable, stops capture and parks the lanes. On release, transmission resumes cleanly at a slot boundary.

Top module: `pixlink_ser7`

## Requirements
- R1: The word on `pix_word` is captured on the falling edge of `pix_clk` while `pd_n` is high and `rst` is low. Later changes before the next falling edge do not alter what is sent.
- R2: Lane k carries bits 7k to 7k+6 of the captured word, with bit 7k sent first and bit 7k+6 sent last.
- R3: A captured word is loaded at the bit-clock edge that samples `slot_strobe` high. Bit j of its slot is driven during the j-th bit cycle after that edge, for j = 0 to 6.
- R4: While enabled, the clock lane sends 1,1,0,0,0,1,1 in bit cycles 0 to 6 of every slot.
- R5: While `pd_n` is low, `lane_oe` is low (from the first edge at the latest), all lane data outputs are 0, and no word is captured.
- R6: After `pd_n` returns high, `lane_oe` rises only on the bit cycle that follows a slot strobe. The first word sent is the first word captured after the release.
- R7: After reset, and whenever `lane_oe` is low, `lane_d` and `clk_lane_d` are 0. `lane_oe` stays low until the first word captured after reset has been loaded.
- R8: Once enabled, a new word is sent in every slot with no idle slot between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held for at least two pixel periods |
| bit_clk | input | 1 | Bit clock, seven times the pixel clock |
| pix_clk | input | 1 | Pixel clock; its falling edge captures the word |
| slot_strobe | input | 1 | One bit-clock cycle high on the last bit cycle of each slot |
| pd_n | input | 1 | Active-low power-down |
| pix_word | input | 28 | Parallel pixel word: colour and timing bits |
| lane_d | output | 4 | Serial data lanes, one bit per bit-clock cycle |
| clk_lane_d | output | 1 | Forwarded clock lane pattern |
| lane_oe | output | 1 | Output enable for all five lane pad buffers |

## Verification
The bench builds the block with its default shape: four lanes, seven-bit slots and the 1100011 clock pattern. This keeps every lane and bit position small enough to visit directly. A walking one and a walking zero go through all 28 input bit positions, and 128 computed words put every seven-bit value on every lane. Power-down is then released at each slot phase other than the capture phase. This reaches both cases: the first word after release is captured in the same slot, or it is captured one slot later.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;
  localparam int          PL_LANES   = 4;
  localparam int          PL_SLOT    = 7;
  localparam logic [6:0]  PL_CLK_PAT = 7'b1100011;  // bit 0 goes out first
endpackage

// File: rtl/pl_capture.sv
// Pixel-domain input register: samples the word on the falling pixel edge and
// toggles a flag per capture so the bit domain can tell a fresh word.
module pl_capture #(
  parameter int WORD = 28
) (
  input  logic            pix_clk,
  input  logic            rst,
  input  logic            pd_n,
  input  logic [WORD-1:0] word_i,
  output logic [WORD-1:0] word_q,
  output logic            cap_tog
);
  always_ff @(negedge pix_clk) begin
    if (rst) begin
      word_q  <= '0;
      cap_tog <= 1'b0;
    end else if (pd_n) begin
      word_q  <= word_i;
      cap_tog <= ~cap_tog;
    end
  end
endmodule

// File: rtl/pl_slot_ctrl.sv
// Bit-domain control: decides on each slot strobe whether to load, and owns the
// drive-enable state across power-down and release.
module pl_slot_ctrl (
  input  logic bit_clk,
  input  logic rst,
  input  logic pd_n,
  input  logic slot_strobe,
  input  logic cap_tog,
  output logic load,
  output logic drv_en
);
  logic seen_tog;
  logic fresh;

  assign fresh = (cap_tog != seen_tog);
  assign load  = pd_n && slot_strobe && (drv_en || fresh);

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      drv_en   <= 1'b0;
      seen_tog <= 1'b0;
    end else if (!pd_n) begin
      drv_en   <= 1'b0;
      seen_tog <= cap_tog;   // discard anything captured before power-down
    end else if (load) begin
      drv_en   <= 1'b1;
      seen_tog <= cap_tog;
    end
  end
endmodule

// File: rtl/pl_shifter.sv
// One lane: parallel load of a slot, then LSB-first shifting.
module pl_shifter #(
  parameter int SLOT = 7
) (
  input  logic            bit_clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SLOT-1:0] slice,
  output logic            bit_o
);
  logic [SLOT-1:0] sh;

  always_ff @(posedge bit_clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= slice;
    else           sh <= {1'b0, sh[SLOT-1:1]};
  end

  assign bit_o = sh[0];
endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7
  import pixlink_pkg::*;
#(
  parameter int              LANES   = PL_LANES,
  parameter int              SLOT    = PL_SLOT,
  parameter logic [SLOT-1:0] CLK_PAT = PL_CLK_PAT,
  localparam int             WORD    = LANES * SLOT
) (
  input  logic             rst,
  input  logic             bit_clk,
  input  logic             pix_clk,
  input  logic             slot_strobe,
  input  logic             pd_n,
  input  logic [WORD-1:0]  pix_word,
  output logic [LANES-1:0] lane_d,
  output logic             clk_lane_d,
  output logic             lane_oe
);
  logic [WORD-1:0]  held_word;
  logic             cap_tog;
  logic             load;
  logic             drv_en;
  logic [LANES-1:0] lane_raw;
  logic             clk_raw;

  pl_capture #(.WORD(WORD)) u_cap (
    .pix_clk (pix_clk),
    .rst     (rst),
    .pd_n    (pd_n),
    .word_i  (pix_word),
    .word_q  (held_word),
    .cap_tog (cap_tog)
  );

  pl_slot_ctrl u_ctrl (
    .bit_clk     (bit_clk),
    .rst         (rst),
    .pd_n        (pd_n),
    .slot_strobe (slot_strobe),
    .cap_tog     (cap_tog),
    .load        (load),
    .drv_en      (drv_en)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pl_shifter #(.SLOT(SLOT)) u_sh (
      .bit_clk (bit_clk),
      .rst     (rst),
      .load    (load),
      .slice   (held_word[k*SLOT +: SLOT]),
      .bit_o   (lane_raw[k])
    );
  end

  pl_shifter #(.SLOT(SLOT)) u_clk_sh (
    .bit_clk (bit_clk),
    .rst     (rst),
    .load    (load),
    .slice   (CLK_PAT),
    .bit_o   (clk_raw)
  );

  assign lane_oe    = pd_n & drv_en;
  assign lane_d     = lane_raw & {LANES{lane_oe}};
  assign clk_lane_d = clk_raw & lane_oe;
endmodule

// File: rtl/pixlink_ser7_chk.sv
module pixlink_ser7_chk #(
  parameter int              LANES   = 4,
  parameter int              SLOT    = 7,
  parameter logic [SLOT-1:0] CLK_PAT = 7'b1100011
) (
  input logic             rst,
  input logic             bit_clk,
  input logic             slot_strobe,
  input logic             pd_n,
  input logic [LANES-1:0] lane_d,
  input logic             clk_lane_d,
  input logic             lane_oe
);
  localparam int PW = $clog2(SLOT + 1);
  localparam logic [(1<<PW)-1:0] PAT_X = {{((1<<PW)-SLOT){1'b0}}, CLK_PAT};

  logic [PW-1:0] ph_q;   // bit position within the current slot; SLOT = unknown
  always_ff @(posedge bit_clk) begin
    if (rst)                     ph_q <= PW'(SLOT);
    else if (slot_strobe)        ph_q <= '0;
    else if (ph_q < PW'(SLOT))   ph_q <= ph_q + PW'(1);
  end

  p_clk_pattern_r4: assert property (@(posedge bit_clk) disable iff (rst)
    (lane_oe && ph_q < PW'(SLOT)) |-> (clk_lane_d == PAT_X[ph_q]));

  p_pd_quiet_r5: assert property (@(posedge bit_clk) disable iff (rst)
    !pd_n |=> !lane_oe);

  p_enable_at_slot_r6: assert property (@(posedge bit_clk) disable iff (rst)
    $rose(lane_oe) |-> $past(slot_strobe));

  p_idle_zero_r7: assert property (@(posedge bit_clk) disable iff (rst)
    !lane_oe |-> (lane_d == '0 && !clk_lane_d));

  p_stream_hold_r8: assert property (@(posedge bit_clk) disable iff (rst)
    (slot_strobe && lane_oe) |=> (lane_oe || !pd_n));
endmodule

bind pixlink_ser7 pixlink_ser7_chk #(.LANES(LANES), .SLOT(SLOT), .CLK_PAT(CLK_PAT)) u_chk (
  .rst         (rst),
  .bit_clk     (bit_clk),
  .slot_strobe (slot_strobe),
  .pd_n        (pd_n),
  .lane_d      (lane_d),
  .clk_lane_d  (clk_lane_d),
  .lane_oe     (lane_oe)
);

// File: tb/sim_pixlink_ser7.sv
module sim_pixlink_ser7;
  localparam int         LANES = 4;
  localparam int         SLOT  = 7;
  localparam int         WORD  = LANES * SLOT;
  localparam logic [6:0] PAT   = 7'b1100011;

  logic            bit_clk = 1'b0;
  logic            rst = 1'b1;
  logic            pix_clk = 1'b1;
  logic            slot_strobe = 1'b0;
  logic            pd_n = 1'b1;
  logic [WORD-1:0] pix_word = '0;
  wire [LANES-1:0] lane_d;
  wire             clk_lane_d;
  wire             lane_oe;

  always #4 bit_clk = ~bit_clk;

  pixlink_ser7 u0 (
    .rst(rst), .bit_clk(bit_clk), .pix_clk(pix_clk), .slot_strobe(slot_strobe),
    .pd_n(pd_n), .pix_word(pix_word), .lane_d(lane_d), .clk_lane_d(clk_lane_d),
    .lane_oe(lane_oe)
  );

  int checks = 0;
  int fails  = 0;
  int ph     = 0;
  int widx   = 0;
  string ctx = "R7";

  // Requirement model state
  logic [WORD-1:0] m_cap = '0, m_cur = '0;
  bit m_new = 0, m_run = 0;

  function automatic logic [WORD-1:0] gen_word(int i);
    logic [WORD-1:0] w;
    if (i < WORD) return WORD'(1) << i;
    if (i < 2*WORD) return ~(WORD'(1) << (i - WORD));
    w = '0;
    for (int k = 0; k < LANES; k++)
      w[k*SLOT +: SLOT] = 7'((i * 5 + k * 37 + 11) % 128);
    return w;
  endfunction

  task automatic chk(string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s phase %0d: actual %b expected %b", tag, ph, act, exp);
    end
  endtask

  // One bit-clock cycle: sample in mid-cycle, then drive the inputs for the next edge.
  task automatic step(bit rst_v, bit pd_v);
    logic             en;
    logic [LANES-1:0] exp_d;
    @(negedge bit_clk);
    en = m_run && pd_n;
    for (int k = 0; k < LANES; k++) exp_d[k] = en ? m_cur[k*SLOT + ph] : 1'b0;  // R2, R3
    chk(ctx, LANES'(lane_oe), LANES'(en));
    chk((ctx == "R6" || ctx == "R5" || ctx == "R7") ? ctx : "R2", lane_d, exp_d);
    chk("R4", LANES'(clk_lane_d), LANES'(en ? PAT[ph] : 1'b0));
    rst  = rst_v;
    pd_n = pd_v;
    if (ph == 0) begin
      pix_word = gen_word(widx);   // R1: changes after capture must not leak through
      widx++;
    end
    pix_clk     = (ph < 3);
    slot_strobe = (ph == 6);
    if (ph == 3) begin            // falling pixel edge happens now
      if (rst)       begin m_cap = '0; m_new = 0; end
      else if (pd_n) begin m_cap = pix_word; m_new = 1; end
    end
    if (rst)        m_run = 0;
    else if (!pd_n) begin m_run = 0; m_new = 0; end
    else if (ph == 6 && (m_run || m_new)) begin  // R8: every slot reloads
      m_cur = m_cap; m_run = 1; m_new = 0;
    end
    ph = (ph + 1) % SLOT;
  endtask

  task automatic go_phase(int p, bit pd_v);
    while (ph != p) step(1'b0, pd_v);
  endtask

  initial begin
    ctx = "R7";
    repeat (3 * SLOT) step(1'b1, 1'b1);
    repeat (2 * SLOT) step(1'b0, 1'b1);           // R7: idle until first load
    ctx = "R2";
    widx = 0;
    repeat (190 * SLOT) step(1'b0, 1'b1);         // R1, R2, R3, R8 sweep
    for (int r = 0; r < SLOT; r++) begin
      if (r == 3) continue;
      go_phase(1, 1'b1);
      ctx = "R5";
      step(1'b0, 1'b0);
      repeat (2 * SLOT) step(1'b0, 1'b0);         // R5: quiet in power-down
      go_phase(r, 1'b0);
      ctx = "R6";
      step(1'b0, 1'b1);                           // release at phase r
      repeat (3 * SLOT) step(1'b0, 1'b1);         // R6: restart at slot edge
      ctx = "R2";
    end
    repeat (3 * SLOT) step(1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule